// File: doc/BRIEF.md
# Serial Register Window for a Real-Time Clock

This block is the two-wire serial target that sits in front of a real-time clock core. A bus master reaches a 16-byte register window through it. The target answers to one 7-bit device address. In a write transfer, the first data byte selects a location in the window and each later byte is stored there. A word pointer steps forward by one after every byte moved, in either direction, and wraps at the top of the window. Because the pointer survives the end of a transfer, a read that follows a write continues from where that write left off.

The lower eight locations are not stored in this block. Reads of them return the live bytes that the timekeeping core presents on a flat input bus. Writes to them are handed to the core through a valid/ready channel. The upper eight locations are local byte registers, used for alarm settings or as general scratch storage.

Two reset inputs exist. The system reset clears everything. The bus reset returns only the protocol engine and the pointer to their idle state.

The core write channel follows these back-pressure rules. `tk_wr_valid` rises one cycle after the last bit of a data byte for a live location has been taken in. While `tk_wr_ready` is low, valid, address and data hold steady. A transfer completes on a cycle where valid and ready are both high. The serial bus cannot be stalled. For that reason the core must accept a write before the next data byte finishes, which takes at least nine SCL periods. A write that is still pending when the next one arrives is replaced by the new one.

Top module: `rtc_i2c_regfile`

## Requirements
- R1: The target acknowledges the address byte A2h (device address 51h with the write bit 0) and A3h (51h with the read bit 1) by pulling SDA low during the ninth clock. It only changes SDA while SCL is low.
- R2: The target does not acknowledge any other address byte. It leaves SDA released for the rest of that transfer, and the data bytes that follow have no effect on storage or on the pointer.
- R3: In a write transfer, the first byte after the address byte is acknowledged and its bits [3:0] load the pointer. Bits [7:4] are ignored.
- R4: Each later byte of a write transfer is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: The pointer wraps from 0Fh to 00h in both reads and writes.
- R6: A read transfer returns the byte at the pointer, MSB first, and advances the pointer after each byte. With no new pointer byte, a read uses the pointer value left by the previous transfer.
- R7: Reading a location from 00h to 07h returns byte n of `tk_rd_data` (bits 8n+7 to 8n), sampled when that byte starts to be sent. Writing such a location produces one transfer on the core write channel, carrying location bits [2:0] and the data.
- R8: While `tk_wr_valid` is high and `tk_wr_ready` is low, valid, address and data keep their values.
- R9: Locations 08h to 0Fh hold the last byte written and return it on reads.
- R10: A low level on `bus_rst_n` returns the protocol engine to idle and the pointer to 00h. It does not change locations 08h to 0Fh and does not cancel a pending core write.
- R11: A STOP ends a transfer. A repeated START begins a new address phase and keeps the pointer. After the master does not acknowledge a read byte, the target releases SDA.
- R12: After the system reset, SDA is released, no core write is pending, the pointer is 00h and locations 08h to 0Fh read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples SCL and SDA |
| rst_n | input | 1 | System reset, active low, clears all state |
| bus_rst_n | input | 1 | Bus reset, active low, clears protocol state and pointer only |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| sda_oe | output | 1 | When high, the target pulls SDA low |
| tk_rd_data | input | 8*LIVE_BYTES | Live bytes of locations 00h to 07h from the timekeeping core |
| tk_wr_valid | output | 1 | A write to a live location is offered to the core |
| tk_wr_ready | input | 1 | The core accepts the offered write |
| tk_wr_addr | output | clog2(LIVE_BYTES) | Live location of the offered write |
| tk_wr_data | output | 8 | Data byte of the offered write |

## Verification
Two functions can fall in the same cycle: a write to a live location can still be waiting for the core's acceptance when the serial engine goes on to the next byte or a bus reset arrives. The bench provokes this by holding `tk_wr_ready` low over a write and pulsing the bus reset while the offer is pending. It judges the outcome at the ports: the offer must stay steady and must finally land in the bench's own copy of the core. Elsewhere, readiness is random, so acceptance and the next byte's reception overlap at varying distances. Every read is compared with a model that tracks the pointer, the scratch bytes and the live bytes.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

  // Serial engine state
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } bus_st_e;

  // What the next received byte means
  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA,
    PH_READ
  } phase_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  // One flop chain per line; idle level of every line is high
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign q_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/rtc_i2c_link.sv
module rtc_i2c_link
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51,
  parameter int         AW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [AW-1:0]     wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr_q
);

  bus_st_e           st;
  phase_e            ph;
  logic              rw_q;
  logic              mack_q;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              scl_d, sda_d;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_DEV;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      sda_oe  <= 1'b0;
      ptr_q   <= '0;
      wr_en   <= 1'b0;
      wr_ptr  <= '0;
      wr_data <= '0;
    end else if (!bus_rst_n) begin
      st     <= ST_IDLE;
      ph     <= PH_DEV;
      mack_q <= 1'b0;
      cnt    <= '0;
      sda_oe <= 1'b0;
      ptr_q  <= '0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st     <= ST_RX;
        ph     <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (ph == PH_DEV && sh[7:1] != DEV_ADDR) begin
                st <= ST_IGNORE;
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (ph == PH_DEV) begin
                  rw_q <= sh[0];
                end else if (ph == PH_PTR) begin
                  ptr_q <= sh[AW-1:0];
                end else begin
                  wr_en   <= 1'b1;
                  wr_ptr  <= ptr_q;
                  wr_data <= sh;
                  ptr_q   <= ptr_q + 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph == PH_DEV && rw_q) begin
                ph     <= PH_READ;
                sda_oe <= ~rd_byte[7];
                sh     <= {rd_byte[6:0], 1'b0};
                cnt    <= 4'd1;
                ptr_q  <= ptr_q + 1'b1;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                ph     <= (ph == PH_DEV) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt < 4'd8) begin
                sda_oe <= ~sh[7];
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end else begin
                sda_oe <= 1'b0;
                mack_q <= 1'b0;
                st     <= ST_MACK;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IGNORE;
              else       mack_q <= 1'b1;
            end else if (scl_fall && mack_q) begin
              mack_q <= 1'b0;
              sda_oe <= ~rd_byte[7];
              sh     <= {rd_byte[6:0], 1'b0};
              cnt    <= 4'd1;
              ptr_q  <= ptr_q + 1'b1;
              st     <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: the target only starts pulling SDA while SCL is low
  p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2: an unanswered transfer never drives the line
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);

  // R5: storing at the top location leaves the pointer at zero
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr == {AW{1'b1}}) |-> (ptr_q == '0));

  // R10: bus reset stops writes and clears the pointer
  p_busrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst_n |=> (!wr_en && ptr_q == '0));

endmodule

// File: rtl/rtc_i2c_store.sv
module rtc_i2c_store
  import rtc_i2c_pkg::*;
#(
  parameter int AW         = 4,
  parameter int LIVE_BYTES = 8,
  localparam int DEPTH     = 2 ** AW,
  localparam int NSCR      = DEPTH - LIVE_BYTES,
  localparam int LW        = $clog2(LIVE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_ptr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [AW-1:0]                rd_ptr,
  input  logic [LIVE_BYTES*BYTE_W-1:0] live_in,
  output logic [BYTE_W-1:0]            rd_byte,
  output logic                         tk_wr_valid,
  input  logic                         tk_wr_ready,
  output logic [LW-1:0]                tk_wr_addr,
  output logic [BYTE_W-1:0]            tk_wr_data
);

  logic [BYTE_W-1:0] scr [NSCR];
  logic              wr_live;

  assign wr_live = (wr_ptr < AW'(LIVE_BYTES));

  // Scratch / alarm bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NSCR; j++) scr[j] <= '0;
    end else if (wr_en && !wr_live) begin
      for (int j = 0; j < NSCR; j++)
        if (wr_ptr == AW'(LIVE_BYTES + j)) scr[j] <= wr_data;
    end
  end

  // Read selection: live bytes below the boundary, scratch above
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < LIVE_BYTES; i++)
      if (rd_ptr == AW'(i)) rd_byte = live_in[i*BYTE_W +: BYTE_W];
    for (int j = 0; j < NSCR; j++)
      if (rd_ptr == AW'(LIVE_BYTES + j)) rd_byte = scr[j];
  end

  // Core write offer, held until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_wr_valid <= 1'b0;
      tk_wr_addr  <= '0;
      tk_wr_data  <= '0;
    end else if (wr_en && wr_live) begin
      tk_wr_valid <= 1'b1;
      tk_wr_addr  <= wr_ptr[LW-1:0];
      tk_wr_data  <= wr_data;
    end else if (tk_wr_valid && tk_wr_ready) begin
      tk_wr_valid <= 1'b0;
    end
  end

  // R8: an unaccepted offer stays put while no new byte arrives
  p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_wr_valid && !tk_wr_ready && !wr_en) |=>
      (tk_wr_valid && $stable(tk_wr_addr) && $stable(tk_wr_data)));

endmodule

// File: rtl/rtc_i2c_regfile.sv
module rtc_i2c_regfile
  import rtc_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h51,
  parameter int         AW          = 4,
  parameter int         LIVE_BYTES  = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        LW          = $clog2(LIVE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe,
  input  logic [LIVE_BYTES*BYTE_W-1:0] tk_rd_data,
  output logic                         tk_wr_valid,
  input  logic                         tk_wr_ready,
  output logic [LW-1:0]                tk_wr_addr,
  output logic [BYTE_W-1:0]            tk_wr_data
);

  logic              scl_s, sda_s, bus_rst_s;
  logic              wr_en;
  logic [AW-1:0]     wr_ptr, ptr_q;
  logic [BYTE_W-1:0] wr_data, rd_byte;

  rtc_i2c_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({bus_rst_n, sda_i, scl_i}),
    .q_out ({bus_rst_s, sda_s, scl_s})
  );

  rtc_i2c_link #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_n (bus_rst_s),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .ptr_q     (ptr_q)
  );

  rtc_i2c_store #(.AW(AW), .LIVE_BYTES(LIVE_BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_data     (wr_data),
    .rd_ptr      (ptr_q),
    .live_in     (tk_rd_data),
    .rd_byte     (rd_byte),
    .tk_wr_valid (tk_wr_valid),
    .tk_wr_ready (tk_wr_ready),
    .tk_wr_addr  (tk_wr_addr),
    .tk_wr_data  (tk_wr_data)
  );

endmodule

// File: tb/test_rtc_i2c_regfile.sv
module test_rtc_i2c_regfile;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_rst_n, m_scl, m_sda, tk_wr_ready, hold_ready;
  logic        sda_oe, tk_wr_valid;
  logic [2:0]  tk_wr_addr;
  logic [7:0]  tk_wr_data;
  logic [63:0] live_rd;
  logic [7:0]  tk_mem [8];
  logic        poke_en;
  logic [2:0]  poke_a;
  logic [7:0]  poke_d;
  wire         sda_line = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] mdl_live [8];
  logic [7:0] mdl_scr [8];
  logic [3:0] mdl_ptr;
  logic [7:0] wbuf [8];

  rtc_i2c_regfile i_rtc_i2c_regfile (
    .clk (clk), .rst_n (rst_n), .bus_rst_n (bus_rst_n),
    .scl_i (m_scl), .sda_i (sda_line), .sda_oe (sda_oe),
    .tk_rd_data (live_rd), .tk_wr_valid (tk_wr_valid),
    .tk_wr_ready (tk_wr_ready), .tk_wr_addr (tk_wr_addr),
    .tk_wr_data (tk_wr_data)
  );

  // Bench stand-in for the timekeeping core
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) tk_mem[i] <= 8'h10 + 8'(i);
    end else if (poke_en) begin
      tk_mem[poke_a] <= poke_d;
    end else if (tk_wr_valid && tk_wr_ready) begin
      tk_mem[tk_wr_addr] <= tk_wr_data;
    end
  end
  always_comb for (int i = 0; i < 8; i++) live_rd[i*8 +: 8] = tk_mem[i];

  always @(negedge clk) tk_wr_ready <= hold_ready ? 1'b0 : 1'($urandom % 2);

  function automatic logic [7:0] exp_at(input logic [3:0] a);
    return a[3] ? mdl_scr[a[2:0]] : mdl_live[a[2:0]];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq(); m_sda = 1'b0; tq(); m_scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq(); m_scl = 1'b1; tq(); m_sda = 1'b1; tq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tq(); m_scl = 1'b1; tq(); tq(); m_scl = 1'b0; tq();
    end
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq();
    ack = !sda_line;
    tq(); m_scl = 1'b0; tq();
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tq(); m_scl = 1'b1; tq(); b[i] = sda_line; tq(); m_scl = 1'b0;
    end
    tq();
    m_sda = give_ack ? 1'b0 : 1'b1;
    tq(); m_scl = 1'b1; tq(); tq(); m_scl = 1'b0; tq();
    m_sda = 1'b1;
  endtask

  task automatic mdl_store(input logic [7:0] d);
    if (mdl_ptr[3]) mdl_scr[mdl_ptr[2:0]] = d;
    else            mdl_live[mdl_ptr[2:0]] = d;
    mdl_ptr = mdl_ptr + 4'd1;
  endtask

  // Write transfer: pointer byte p, then n bytes from wbuf
  task automatic do_write(input logic [7:0] p, input int n);
    bit ack;
    bus_start();
    wr_byte(8'hA2, ack); chk(ack, "R1 write address ack", 32'(ack), 1);
    wr_byte(p, ack);     chk(ack, "R3 pointer byte ack", 32'(ack), 1);
    mdl_ptr = p[3:0];
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], ack); chk(ack, "R4 data byte ack", 32'(ack), 1);
      mdl_store(wbuf[i]);
    end
    bus_stop();
    repeat (40) @(negedge clk);
  endtask

  // Read transfer of n bytes from the current pointer, last one not acknowledged
  task automatic do_read(input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hA3, ack); chk(ack, "R1 read address ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, b);
      chk(b == exp_at(mdl_ptr), "R6 read data", 32'(b), 32'(exp_at(mdl_ptr)));
      mdl_ptr = mdl_ptr + 4'd1;
    end
    chk(sda_oe == 1'b0, "R11 release after master nack", 32'(sda_oe), 0);
    bus_stop();
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_bus_rst();
    bus_rst_n = 1'b0; repeat (5) @(negedge clk); bus_rst_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_rst_n = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
    hold_ready = 1'b0; poke_en = 1'b0; poke_a = '0; poke_d = '0;
    for (int i = 0; i < 8; i++) begin mdl_live[i] = 8'h10 + 8'(i); mdl_scr[i] = 8'h00; end
    mdl_ptr = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk(sda_oe == 1'b0, "R12 sda released", 32'(sda_oe), 0);
    chk(tk_wr_valid == 1'b0, "R12 no pending write", 32'(tk_wr_valid), 0);
    do_read(1); // pointer 00h after reset
    do_write(8'h08, 0);
    do_read(8); // R12 / R9: scratch cleared

    // R5: write wrap 0Eh,0Fh,00h then read continues at 01h (R6)
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h77;
    do_write(8'h0E, 3);
    do_read(2);
    // R5: read wrap
    do_write(8'h0F, 0);
    do_read(2);

    // R11: repeated start keeps pointer; R3 upper bits ignored
    bus_start();
    wr_byte(8'hA2, ack);
    wr_byte(8'hF5, ack); chk(ack, "R3 pointer with high bits", 32'(ack), 1);
    mdl_ptr = 4'h5;
    bus_start();
    wr_byte(8'hA3, ack); chk(ack, "R11 address after repeated start", 32'(ack), 1);
    rd_byte(1'b1, b); chk(b == exp_at(4'h5), "R11 read after repeated start", 32'(b), 32'(exp_at(4'h5)));
    rd_byte(1'b0, b); chk(b == exp_at(4'h6), "R11 second byte", 32'(b), 32'(exp_at(4'h6)));
    mdl_ptr = 4'h7;
    bus_stop(); repeat (10) @(negedge clk);

    // R2: foreign address
    bus_start();
    wr_byte(8'hA4, ack); chk(!ack, "R2 foreign address not acked", 32'(ack), 0);
    wr_byte(8'h09, ack); chk(!ack, "R2 later byte not acked", 32'(ack), 0);
    wr_byte(8'hEE, ack); chk(!ack, "R2 data ignored", 32'(ack), 0);
    bus_stop(); repeat (10) @(negedge clk);
    do_read(3); // pointer still 07h, 08h..09h untouched

    // R8 and R10: held offer survives bus reset
    hold_ready = 1'b1;
    wbuf[0] = 8'h5A;
    do_write(8'h03, 1);
    chk(tk_wr_valid == 1'b1, "R8 offer pending", 32'(tk_wr_valid), 1);
    chk(tk_wr_addr == 3'd3, "R7 offer address", 32'(tk_wr_addr), 3);
    chk(tk_wr_data == 8'h5A, "R7 offer data", 32'(tk_wr_data), 32'h5A);
    pulse_bus_rst();
    repeat (30) @(negedge clk);
    chk(tk_wr_valid && tk_wr_addr == 3'd3 && tk_wr_data == 8'h5A, "R8 R10 offer held",
        {tk_wr_valid, tk_wr_addr, tk_wr_data}, {1'b1, 3'd3, 8'h5A});
    hold_ready = 1'b0;
    repeat (20) @(negedge clk);
    chk(tk_mem[3] == 8'h5A, "R7 core received write", 32'(tk_mem[3]), 32'h5A);
    chk(tk_wr_valid == 1'b0, "R8 offer retired", 32'(tk_wr_valid), 0);
    mdl_ptr = 4'h0;
    do_read(1); // R10: pointer back to 00h

    // R7: live value changed by the core
    poke_a = 3'd6; poke_d = 8'hC3; poke_en = 1'b1; @(negedge clk); poke_en = 1'b0;
    mdl_live[6] = 8'hC3;
    do_write(8'h06, 0);
    do_read(1);

    // R10: bus reset in mid transfer keeps scratch
    wbuf[0] = 8'h99;
    do_write(8'h0A, 1);
    bus_start();
    wr_byte(8'hA2, ack);
    wr_byte(8'h0C, ack);
    pulse_bus_rst();
    bus_stop(); repeat (10) @(negedge clk);
    mdl_ptr = 4'h0;
    do_read(1);
    do_write(8'h0A, 0);
    do_read(1); // R10 scratch kept

    // Random mix
    for (int t = 0; t < 30; t++) begin
      int k;
      k = int'($urandom % 4);
      if (k == 0) begin
        int n;
        n = 1 + int'($urandom % 4);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(8'($urandom), n);
      end else if (k == 1) begin
        do_read(1 + int'($urandom % 4));
      end else if (k == 2) begin
        do_write(8'($urandom), 0);
        do_read(1 + int'($urandom % 3));
      end else begin
        logic [7:0] bad;
        bad = 8'($urandom);
        if (bad[7:1] == 7'h51) bad = 8'h30;
        bus_start();
        wr_byte(bad, ack); chk(!ack, "R2 random foreign address", 32'(ack), 0);
        wr_byte(8'($urandom), ack);
        bus_stop(); repeat (10) @(negedge clk);
      end
    end

    // Final: core copy matches model (R7)
    for (int i = 0; i < 8; i++)
      chk(tk_mem[i] == mdl_live[i], "R7 core contents", 32'(tk_mem[i]), 32'(mdl_live[i]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule